// File: doc/BRIEF.md
# External Memory Access Sequencer

This block sits between a processor core and its external memory bus. Each instruction may need a coefficient fetch from the external coefficient ROM, a data-space access (read or write), both, or neither. The sequencer turns each request into a strict series of bus steps. Every step drives exactly one active-low segment strobe, and the coefficient step always runs before the data step. While steps remain, a stall line holds the core. When the core's request is internal only, the external address bus keeps its last external value.

Per-segment wait-state fields stretch each step. Three control inputs change how data accesses are mapped and timed. The redirect input moves every data-space access onto the ROM strobe. The download-extension input, together with redirect, folds the upper half of the address space onto the lower half. The late-edge input delays the leading edge of each strobe by half a clock period, so that two devices do not drive the data bus at the same time.

Top module: `ext_mem_seq`

## Requirements
- R1: While `rstN` is low, `addrDrive` is low (bus released), all strobes are high, `stall` is low and `rdWrN` is high.
- R2: A request with both `coefNeed` and `dataNeed` runs the coefficient step first (strobe bit 0) and then the data step. `stall` is high during the coefficient step and low in the last cycle of the data step.
- R3: With all wait fields zero, every step lasts one cycle. A request presented while `stall` is low is accepted at the next rising edge and its first step appears right after that edge, so two two-access requests presented back to back fill four consecutive strobe cycles.
- R4: `rdWrN` is low only during the cycles of a data write step. It is high again in the first cycle after that step, which gives zero write hold.
- R5: `waitCfg` holds one field of `WAIT_W` bits per strobe: segment s uses bits [4s+3:4s]. Segment 0 is ROM, 1 is data RAM low, 2 is I/O and 3 is data RAM high, and strobe bit s belongs to segment s. A step lasts one cycle plus the field of its segment, and `stall` stays high until the last cycle of the last step.
- R6: With `redirect` high, a data step asserts strobe bit 0 (ROM) instead of the segment given by `dataSeg`, and it uses the ROM wait field.
- R7: With `redirect` and `extDownload` both high, address bit 15 is driven low on every external step. `extDownload` alone leaves the address unchanged.
- R8: A request with neither need drives no strobe and leaves `addrOut` at the last external address.
- R9: At most one strobe is low at any time.
- R10: With `lateEdge` high, a strobe that was inactive in the previous cycle goes low only after the falling clock edge. With `lateEdge` low, it goes low right after the rising edge.
- R11: While `stall` is high, the request inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present; consumed at the rising edge when `stall` is low |
| coefNeed | input | 1 | Request needs a coefficient fetch |
| coefAddr | input | 16 | Coefficient fetch address |
| dataNeed | input | 1 | Request needs a data-space access |
| dataAddr | input | 16 | Data access address |
| dataSeg | input | 2 | Data strobe index: 1 RAM low, 2 I/O, 3 RAM high |
| dataWrite | input | 1 | Data access is a write |
| waitCfg | input | 16 | Wait-state fields, 4 bits per segment |
| redirect | input | 1 | Map data accesses onto the ROM strobe |
| extDownload | input | 1 | With `redirect`, force address bit 15 low |
| lateEdge | input | 1 | Delay strobe leading edges by half a clock |
| addrOut | output | 16 | External address |
| addrDrive | output | 1 | Address bus driven (low means released) |
| segStrbN | output | 4 | Segment strobes, active low |
| rdWrN | output | 1 | High for read, low for write |
| stall | output | 1 | Core must hold its request |

## Verification
The bench builds the block with its default values: a 16-bit address, 4-bit wait fields and four segments. With these values, address folding acts on bit 15 and each wait field can stretch a step by up to fifteen cycles. The bench uses wait fields of 0, 1 and 2, which is enough to show multi-cycle steps in the ROM and I/O segments and stalled requests being ignored. Strobes are sampled on both sides of the falling edge, so the half-cycle delay of the leading edge can be seen at the ports.

// File: rtl/ext_seq_pkg.sv
package ext_seq_pkg;
  typedef enum logic [1:0] {
    ADDR_HOLD  = 2'd0,
    ADDR_COEF  = 2'd1,
    ADDR_DATA  = 2'd2,
    ADDR_SAVED = 2'd3
  } addrSrc_e;

  typedef struct packed {
    logic     capture;  // latch the data half of a split request
    addrSrc_e addrSrc;  // which address and segment start a step
    logic     active;   // a step occupies the bus this cycle
  } seqCtl_t;
endpackage

// File: rtl/ext_seq_control.sv
module ext_seq_control
  import ext_seq_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              coefNeed,
  input  logic              dataNeed,
  input  logic [WAIT_W-1:0] coefWait,
  input  logic [WAIT_W-1:0] liveDataWait,
  input  logic [WAIT_W-1:0] savedDataWait,
  output seqCtl_t           ctl,
  output logic              stall
);
  logic busy, isData, dataPend;
  logic [WAIT_W-1:0] cnt;
  logic stepDone, moreData, lastCycle, accept, startAny;

  always_comb begin
    stepDone  = busy && (cnt == '0);
    moreData  = !isData && dataPend;
    lastCycle = stepDone && !moreData;
    stall     = busy && !lastCycle;
    accept    = reqValid && !stall;
    startAny  = accept && (coefNeed || dataNeed);

    ctl.capture = startAny;
    ctl.active  = busy;
    if (startAny)
      ctl.addrSrc = coefNeed ? ADDR_COEF : ADDR_DATA;
    else if (stepDone && moreData)
      ctl.addrSrc = ADDR_SAVED;
    else
      ctl.addrSrc = ADDR_HOLD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      isData   <= 1'b0;
      dataPend <= 1'b0;
      cnt      <= '0;
    end else if (startAny) begin
      busy     <= 1'b1;
      isData   <= !coefNeed;
      dataPend <= coefNeed && dataNeed;
      cnt      <= coefNeed ? coefWait : liveDataWait;
    end else if (stepDone && moreData) begin
      isData   <= 1'b1;
      dataPend <= 1'b0;
      cnt      <= savedDataWait;
    end else if (stepDone) begin
      busy     <= 1'b0;
    end else if (busy) begin
      cnt      <= cnt - WAIT_W'(1);
    end
  end

  // R2: a finished coefficient step with a data step pending moves to the data step
  p_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy && !isData && dataPend && (cnt == '0) |=> busy && isData);

  // R5: a step with wait cycles left stays in the same phase and counts down by one
  p_wait_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy && (cnt != '0) |=> busy && $stable(isData) && (cnt == $past(cnt) - WAIT_W'(1)));

  // R11: a stalled cycle is always followed by another bus cycle
  p_stall_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> busy);
endmodule

// File: rtl/ext_seq_datapath.sv
module ext_seq_datapath
  import ext_seq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WAIT_W  = 4,
  parameter int NUM_SEG = 4,
  parameter int SEG_W   = $clog2(NUM_SEG)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqCtl_t                   ctl,
  input  logic [ADDR_W-1:0]         coefAddr,
  input  logic [ADDR_W-1:0]         dataAddr,
  input  logic [SEG_W-1:0]          dataSeg,
  input  logic                      dataWrite,
  input  logic [NUM_SEG*WAIT_W-1:0] waitCfg,
  input  logic                      redirect,
  input  logic                      extDownload,
  input  logic                      lateEdge,
  output logic [WAIT_W-1:0]         coefWait,
  output logic [WAIT_W-1:0]         liveDataWait,
  output logic [WAIT_W-1:0]         savedDataWait,
  output logic [ADDR_W-1:0]         addrQ,
  output logic                      addrDrive,
  output logic [NUM_SEG-1:0]        strbOut,
  output logic                      rdWrN
);
  localparam logic [SEG_W-1:0] ROM_SEG = '0;

  logic [ADDR_W-1:0]  dataAddrQ;
  logic [SEG_W-1:0]   dataSegQ, stepSeg, liveSeg;
  logic               dataWrQ, foldQ, stepWr, liveFold;
  logic [NUM_SEG-1:0] strbAct, armed;

  function automatic logic [ADDR_W-1:0] foldAddr(input logic [ADDR_W-1:0] a, input logic doFold);
    logic [ADDR_W-1:0] r;
    r = a;
    if (doFold) r[ADDR_W-1] = 1'b0;
    return r;
  endfunction

  always_comb begin
    liveFold      = redirect && extDownload;
    liveSeg       = redirect ? ROM_SEG : dataSeg;
    coefWait      = waitCfg[0 +: WAIT_W];
    liveDataWait  = waitCfg[liveSeg*WAIT_W +: WAIT_W];
    savedDataWait = waitCfg[dataSegQ*WAIT_W +: WAIT_W];
    strbAct       = ctl.active ? (NUM_SEG'(1) << stepSeg) : '0;
    strbOut       = strbAct & (lateEdge ? armed : '1);
    rdWrN         = !(ctl.active && stepWr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataAddrQ <= '0;
      dataSegQ  <= '0;
      dataWrQ   <= 1'b0;
      foldQ     <= 1'b0;
    end else if (ctl.capture) begin
      dataAddrQ <= dataAddr;
      dataSegQ  <= liveSeg;
      dataWrQ   <= dataWrite;
      foldQ     <= liveFold;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      stepSeg <= '0;
      stepWr  <= 1'b0;
    end else begin
      unique case (ctl.addrSrc)
        ADDR_COEF: begin
          addrQ   <= foldAddr(coefAddr, liveFold);
          stepSeg <= ROM_SEG;
          stepWr  <= 1'b0;
        end
        ADDR_DATA: begin
          addrQ   <= foldAddr(dataAddr, liveFold);
          stepSeg <= liveSeg;
          stepWr  <= dataWrite;
        end
        ADDR_SAVED: begin
          addrQ   <= foldAddr(dataAddrQ, foldQ);
          stepSeg <= dataSegQ;
          stepWr  <= dataWrQ;
        end
        default: ;
      endcase
    end
  end

  // a strobe counts as already running once it has been active across a falling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) armed <= '0;
    else       armed <= strbAct;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrDrive <= 1'b0;
    else       addrDrive <= 1'b1;
  end

  // R6: a redirected data step lands on the ROM strobe
  p_redirect_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.addrSrc == ADDR_DATA) && redirect |=> strbAct[0]);

  // R7: folded steps never drive the top address bit
  p_alias_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.addrSrc != ADDR_HOLD) && (ctl.addrSrc == ADDR_SAVED ? foldQ : liveFold)
      |=> !addrQ[ADDR_W-1]);
endmodule

// File: rtl/ext_mem_seq.sv
module ext_mem_seq
  import ext_seq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WAIT_W  = 4,
  parameter int NUM_SEG = 4,
  parameter int SEG_W   = $clog2(NUM_SEG)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      coefNeed,
  input  logic [ADDR_W-1:0]         coefAddr,
  input  logic                      dataNeed,
  input  logic [ADDR_W-1:0]         dataAddr,
  input  logic [SEG_W-1:0]          dataSeg,
  input  logic                      dataWrite,
  input  logic [NUM_SEG*WAIT_W-1:0] waitCfg,
  input  logic                      redirect,
  input  logic                      extDownload,
  input  logic                      lateEdge,
  output logic [ADDR_W-1:0]         addrOut,
  output logic                      addrDrive,
  output logic [NUM_SEG-1:0]        segStrbN,
  output logic                      rdWrN,
  output logic                      stall
);
  seqCtl_t            ctl;
  logic [WAIT_W-1:0]  coefWait, liveDataWait, savedDataWait;
  logic [NUM_SEG-1:0] strbOut;

  ext_seq_control #(.WAIT_W(WAIT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .coefNeed(coefNeed),
    .dataNeed(dataNeed), .coefWait(coefWait), .liveDataWait(liveDataWait),
    .savedDataWait(savedDataWait), .ctl(ctl), .stall(stall)
  );

  ext_seq_datapath #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .coefAddr(coefAddr), .dataAddr(dataAddr),
    .dataSeg(dataSeg), .dataWrite(dataWrite), .waitCfg(waitCfg), .redirect(redirect),
    .extDownload(extDownload), .lateEdge(lateEdge), .coefWait(coefWait),
    .liveDataWait(liveDataWait), .savedDataWait(savedDataWait), .addrQ(addrOut),
    .addrDrive(addrDrive), .strbOut(strbOut), .rdWrN(rdWrN)
  );

  assign segStrbN = ~strbOut;

  // R9: never more than one segment selected
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~segStrbN));

  // R4: the write line is only low while a strobe is driven
  p_write_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rdWrN && !lateEdge |-> !(&segStrbN));
endmodule

// File: tb/test_ext_mem_seq.sv
`timescale 1ns/1ps
module test_ext_mem_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, coefNeed = 1'b0, dataNeed = 1'b0, dataWrite = 1'b0;
  logic [15:0] coefAddr = '0, dataAddr = '0, waitCfg = '0;
  logic [1:0]  dataSeg = '0;
  logic        redirect = 1'b0, extDownload = 1'b0, lateEdge = 1'b0;
  logic [15:0] addrOut;
  logic        addrDrive, rdWrN, stall;
  logic [3:0]  segStrbN;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_mem_seq i_ext_mem_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .coefNeed(coefNeed), .coefAddr(coefAddr),
    .dataNeed(dataNeed), .dataAddr(dataAddr), .dataSeg(dataSeg), .dataWrite(dataWrite),
    .waitCfg(waitCfg), .redirect(redirect), .extDownload(extDownload), .lateEdge(lateEdge),
    .addrOut(addrOut), .addrDrive(addrDrive), .segStrbN(segStrbN), .rdWrN(rdWrN), .stall(stall)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic present(input logic cN, input logic [15:0] cA, input logic dN,
                         input logic [15:0] dA, input logic [1:0] sg, input logic wr);
    reqValid = 1'b1; coefNeed = cN; coefAddr = cA;
    dataNeed = dN; dataAddr = dA; dataSeg = sg; dataWrite = wr;
  endtask

  task automatic release_req();
    reqValid = 1'b0; coefNeed = 1'b0; dataNeed = 1'b0; dataWrite = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 addrDrive", 32'(addrDrive), 32'd0);
    chk("R1 strobes", 32'(segStrbN), 32'hF);
    chk("R1 stall", 32'(stall), 32'd0);
    chk("R1 rdWrN", 32'(rdWrN), 32'd1);
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    cyc();
    chk("R1 addrDrive after reset", 32'(addrDrive), 32'd1);
  endtask

  task automatic t_split_order();
    present(1, 16'h0100, 1, 16'h0200, 2'd1, 0);
    cyc();
    release_req();
    chk("R2 coef first strobe", 32'(segStrbN), 32'hE);
    chk("R2 coef address", 32'(addrOut), 32'h0100);
    chk("R2 stall in coef step", 32'(stall), 32'd1);
    cyc();
    chk("R2 R9 data strobe", 32'(segStrbN), 32'hD);
    chk("R2 data address", 32'(addrOut), 32'h0200);
    chk("R2 stall low in last step", 32'(stall), 32'd0);
    cyc();
    chk("R2 idle after", 32'(segStrbN), 32'hF);
  endtask

  task automatic t_back_to_back();
    present(1, 16'h0010, 1, 16'h0020, 2'd3, 0);
    cyc();
    release_req();
    chk("R3 step1 ROM", 32'(segStrbN), 32'hE);
    cyc();
    chk("R3 step2 RAM high", 32'(segStrbN), 32'h7);
    chk("R3 step2 stall", 32'(stall), 32'd0);
    present(1, 16'h0030, 1, 16'h0040, 2'd2, 1);
    cyc();
    release_req();
    chk("R3 step3 ROM", 32'(segStrbN), 32'hE);
    chk("R3 step3 address", 32'(addrOut), 32'h0030);
    chk("R4 read during coef", 32'(rdWrN), 32'd1);
    cyc();
    chk("R3 R9 step4 I/O", 32'(segStrbN), 32'hB);
    chk("R4 write low", 32'(rdWrN), 32'd0);
    cyc();
    chk("R4 zero hold rdWrN", 32'(rdWrN), 32'd1);
    chk("R4 strobes released", 32'(segStrbN), 32'hF);
  endtask

  task automatic t_wait_states();
    waitCfg = 16'h0201;  // I/O field 2, ROM field 1
    present(0, 16'h0, 1, 16'h0055, 2'd2, 0);
    cyc();
    release_req();
    chk("R5 I/O cycle1", 32'(segStrbN), 32'hB);
    chk("R5 stall cycle1", 32'(stall), 32'd1);
    cyc();
    chk("R5 I/O cycle2", 32'(segStrbN), 32'hB);
    chk("R5 stall cycle2", 32'(stall), 32'd1);
    cyc();
    chk("R5 I/O cycle3", 32'(segStrbN), 32'hB);
    chk("R5 stall low last", 32'(stall), 32'd0);
    cyc();
    chk("R5 I/O done", 32'(segStrbN), 32'hF);
    present(1, 16'h0077, 0, 16'h0, 2'd0, 0);
    cyc();
    release_req();
    chk("R5 ROM wait stall", 32'(stall), 32'd1);
    cyc();
    chk("R5 ROM cycle2", 32'(segStrbN), 32'hE);
    chk("R5 ROM last stall", 32'(stall), 32'd0);
    cyc();
    chk("R5 ROM done", 32'(segStrbN), 32'hF);
  endtask

  task automatic t_stall_ignore();
    waitCfg = 16'h0200;
    present(0, 16'h0, 1, 16'h0066, 2'd2, 0);
    cyc();
    present(1, 16'h7777, 1, 16'h5555, 2'd1, 1);  // must be ignored while stalled
    chk("R11 stalled", 32'(stall), 32'd1);
    cyc();
    chk("R11 address kept", 32'(addrOut), 32'h0066);
    chk("R11 strobe kept", 32'(segStrbN), 32'hB);
    cyc();
    chk("R11 last cycle", 32'(stall), 32'd0);
    release_req();
    cyc();
    chk("R11 idle after", 32'(segStrbN), 32'hF);
    chk("R11 no junk address", 32'(addrOut), 32'h0066);
    chk("R11 no junk write", 32'(rdWrN), 32'd1);
  endtask

  task automatic t_redirect();
    waitCfg = 16'h0001;
    redirect = 1'b1;
    present(0, 16'h0, 1, 16'h0300, 2'd1, 0);
    cyc();
    release_req();
    chk("R6 ROM strobe for data", 32'(segStrbN), 32'hE);
    chk("R6 ROM wait used", 32'(stall), 32'd1);
    cyc();
    chk("R6 second cycle", 32'(stall), 32'd0);
    cyc();
    chk("R6 done", 32'(segStrbN), 32'hF);
    redirect = 1'b0;
    waitCfg = 16'h0000;
  endtask

  task automatic t_alias();
    redirect = 1'b1; extDownload = 1'b1;
    present(0, 16'h0, 1, 16'h9234, 2'd3, 1);
    cyc();
    release_req();
    chk("R7 folded address", 32'(addrOut), 32'h1234);
    chk("R7 ROM strobe write", 32'(segStrbN), 32'hE);
    chk("R7 write line", 32'(rdWrN), 32'd0);
    cyc();
    redirect = 1'b0;
    present(0, 16'h0, 1, 16'h9234, 2'd3, 0);
    cyc();
    release_req();
    chk("R7 ext alone no fold", 32'(addrOut), 32'h9234);
    chk("R7 ext alone segment", 32'(segStrbN), 32'h7);
    cyc();
    extDownload = 1'b0;
  endtask

  task automatic t_internal();
    present(0, 16'h1111, 0, 16'h2222, 2'd1, 1);
    cyc();
    release_req();
    chk("R8 no strobe", 32'(segStrbN), 32'hF);
    chk("R8 address held", 32'(addrOut), 32'h9234);
    chk("R8 no stall", 32'(stall), 32'd0);
    chk("R8 read line", 32'(rdWrN), 32'd1);
  endtask

  task automatic t_late_edge();
    lateEdge = 1'b1;
    present(1, 16'h0044, 1, 16'h0088, 2'd1, 0);
    cyc();
    release_req();
    chk("R10 coef edge delayed", 32'(segStrbN), 32'hF);
    #2;
    chk("R10 coef after fall", 32'(segStrbN), 32'hE);
    cyc();
    chk("R10 data edge delayed", 32'(segStrbN), 32'hF);
    #2;
    chk("R10 data after fall", 32'(segStrbN), 32'hD);
    cyc();
    lateEdge = 1'b0;
    present(0, 16'h0, 1, 16'h0099, 2'd1, 0);
    cyc();
    release_req();
    chk("R10 no delay when off", 32'(segStrbN), 32'hD);
    cyc();
  endtask

  initial begin
    t_reset();
    t_split_order();
    t_back_to_back();
    t_wait_states();
    t_stall_ignore();
    t_redirect();
    t_alias();
    t_internal();
    t_late_edge();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule